// File: doc/BRIEF.md
# Multichannel Alarm Status Aggregator

This block collects alarm events from eight serial link channels, arranged as two groups of four lanes. Each channel signals two kinds of alarm, loss of frame alignment and parity-check error, as single-cycle pulses. The block holds each event in a sticky status bit. A per-alarm enable bit masks it. The enabled alarms of each channel combine into one summary bit, and any set summary bit raises a level interrupt.

Software reaches the block over a plain 8-bit register bus. The bus has separate read and write strobes, a parity input and a parity output. A read of a channel's status register returns the held alarms and clears them. The register window also holds four read-only identification bytes. The window answers only when the upper address bits match a fixed base offset.

Channel index c runs 0..7 in the order AA, AB, AC, AD, BA, BB, BC, BD. Register offsets are counted from the base. In every status and enable byte, bit 0 is the frame alarm and bit 1 is the parity alarm.

Top module: `alarm_status_agg`

## Requirements
- R1: Offsets 0x00, 0x01, 0x02 and 0x03 read 0xDC, 0x01, 0x22 and 0x82. Writes to these offsets change nothing.
- R2: An access takes effect only when address bits [17:5] equal 0x1800, which is base 0x30000. Any other read or write changes no register and leaves the read data unchanged.
- R3: A pulse on oof_evt[c] sets bit 0 of the status byte at offset 0x08+c. A pulse on par_evt[c] sets bit 1 of that byte. The bit is set one clock after the pulse.
- R4: A read of the status byte at 0x08+c returns its contents on the clock after the read strobe. That byte is then zero, unless an event arrived in the same cycle.
- R5: An event in the same cycle as a clearing read of its channel stays set. That read returns the value held before the event.
- R6: The enable byte at 0x10+c holds written bits [1:0], reads back with bits [7:2] zero, and is zero after reset.
- R7: Bit c of the summary byte at 0x04 is set when channel c has any status bit whose enable bit is also set. Reading the summary byte clears nothing.
- R8: alarm_irq is high exactly while at least one summary bit is set. It stays high until reads clear every enabled alarm.
- R9: oof_raw[c] and par_raw[c] show the held status bits of channel c without masking.
- R10: bus_wpar has no effect, and bus_rpar is always 0.
- R11: Mapped offsets with no register read 0x00. bus_rdata keeps its value while no read strobe is given.
- R12: After reset, every status and enable bit is clear, bus_rdata is 0x00 and alarm_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 18 | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_wpar | input | 1 | Write parity, not checked |
| bus_rdata | output | 8 | Registered read data |
| bus_rpar | output | 1 | Read parity, held at 0 |
| oof_evt | input | 8 | Per-channel frame-loss event pulses |
| par_evt | input | 8 | Per-channel parity-error event pulses |
| oof_raw | output | 8 | Held frame-loss status, unmasked |
| par_raw | output | 8 | Held parity-error status, unmasked |
| alarm_irq | output | 1 | Level interrupt, any enabled alarm held |

## Verification
The bench uses the default parameters: two groups of four lanes, an 18-bit address and base 0x30000. With these values all eight channels fill the 5-bit local window. The bench can therefore reach the highest-numbered status and enable bytes and the last unmapped offset 0x1F. The same setup lets the bench aim events at one channel while reads clear a different channel or the same one. It also lets the bench give off-base addresses that differ from the window only above bit 5.

// File: rtl/alarm_agg_pkg.sv
// Package: constants shared by the alarm aggregator modules.
// Assumes two alarm kinds per channel. Bit 0 is loss of frame, bit 1 is parity error.
package alarm_agg_pkg;
    localparam int          N_ALM   = 2;
    localparam int          ALM_OOF = 0;
    localparam int          ALM_PAR = 1;
    localparam logic [31:0] DEV_ID  = 32'hDC01_2282;
    localparam int          ID_LEN  = 4;
    localparam int          OFF_SUM = 4;
endpackage

// File: rtl/alarm_chan_stat.sv
// Module: sticky alarm status and enable mask for one channel.
// Events are single-cycle pulses. An event in a clearing cycle wins over the clear.
// Assumes that only the bus decoder drives clr and en_wr.
module alarm_chan_stat
    import alarm_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ALM-1:0] evt,
    input  logic             clr,
    input  logic             en_wr,
    input  logic [N_ALM-1:0] en_wdata,
    output logic [N_ALM-1:0] stat,
    output logic [N_ALM-1:0] en,
    output logic             summ
);
    // Hold events; a clearing read drops old bits but keeps new ones.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (clr ? '0 : stat) | evt;
    end

    // Enable mask, loaded by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= en_wdata;
    end

    // Channel summary: any enabled held alarm.
    always_comb summ = |(stat & en);
endmodule

// File: rtl/alarm_bus_dec.sv
// Module: address decode, read multiplexer and read-data register.
// Assumes N_CH <= 8 and N_ALM <= 8, so each field fits in a byte.
// Single-cycle strobes; read data appears on the clock after the read strobe.
module alarm_bus_dec
    import alarm_agg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int LOCAL_W  = 5,
    parameter int N_CH     = 8,
    parameter int OFF_STAT = 8,
    parameter int OFF_EN   = 16,
    parameter int BASE     = 32'h30000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [N_CH*N_ALM-1:0] stat_flat,
    input  logic [N_CH*N_ALM-1:0] en_flat,
    input  logic [N_CH-1:0]       summ,
    output logic [N_CH-1:0]       clr,
    output logic [N_CH-1:0]       en_wr,
    output logic [7:0]            rdata
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

    logic               hit;
    logic [LOCAL_W-1:0] off;
    logic [7:0]         rd_val;

    // Base match and local offset.
    always_comb begin
        hit = (addr[ADDR_W-1:LOCAL_W] == BASE_V[ADDR_W-1:LOCAL_W]);
        off = addr[LOCAL_W-1:0];
    end

    // Read multiplexer over the identification, summary, status and enable bytes.
    always_comb begin
        rd_val = 8'h00;
        if (int'(off) < ID_LEN)
            rd_val = DEV_ID[8*(ID_LEN-1-int'(off)) +: 8];
        if (off == LOCAL_W'(OFF_SUM))
            rd_val = 8'(summ);
        for (int c = 0; c < N_CH; c++) begin
            if (off == LOCAL_W'(OFF_STAT + c))
                rd_val = 8'(stat_flat[c*N_ALM +: N_ALM]);
            if (off == LOCAL_W'(OFF_EN + c))
                rd_val = 8'(en_flat[c*N_ALM +: N_ALM]);
        end
    end

    // Per-channel clear-on-read and enable-write strobes.
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            clr[c]   = rd && hit && (off == LOCAL_W'(OFF_STAT + c));
            en_wr[c] = wr && hit && (off == LOCAL_W'(OFF_EN + c));
        end
    end

    // Read-data register; holds when no read hits the window.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata <= 8'h00;
        else if (rd && hit) rdata <= rd_val;
    end
endmodule

// File: rtl/alarm_status_agg.sv
// Module: top of the alarm aggregator for N_GRP groups of N_LANE channels.
// Channel index is group*N_LANE + lane.
// Write parity is accepted and not checked; read parity is tied to zero.
// Assumes one-cycle strobes and one-cycle event pulses, all synchronous to clk.
module alarm_status_agg
    import alarm_agg_pkg::*;
#(
    parameter int N_GRP  = 2,
    parameter int N_LANE = 4,
    parameter int ADDR_W = 18,
    parameter int BASE   = 32'h30000,
    localparam int N_CH  = N_GRP * N_LANE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wpar,
    output logic [7:0]        bus_rdata,
    output logic              bus_rpar,
    input  logic [N_CH-1:0]   oof_evt,
    input  logic [N_CH-1:0]   par_evt,
    output logic [N_CH-1:0]   oof_raw,
    output logic [N_CH-1:0]   par_raw,
    output logic              alarm_irq
);
    localparam int OFF_STAT = 8;
    localparam int OFF_EN   = OFF_STAT + N_CH;
    localparam int LOCAL_W  = $clog2(OFF_EN + N_CH);

    logic [N_CH*N_ALM-1:0] stat_flat;
    logic [N_CH*N_ALM-1:0] en_flat;
    logic [N_CH-1:0]       summ;
    logic [N_CH-1:0]       clr;
    logic [N_CH-1:0]       en_wr;
    logic                  unused_bits;

    // Parity input and unused data bits: consumed only to show they are ignored.
    always_comb unused_bits = ^{bus_wpar, bus_wdata};

    alarm_bus_dec #(
        .ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .N_CH(N_CH),
        .OFF_STAT(OFF_STAT), .OFF_EN(OFF_EN), .BASE(BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .stat_flat(stat_flat), .en_flat(en_flat), .summ(summ),
        .clr(clr), .en_wr(en_wr), .rdata(bus_rdata)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [N_ALM-1:0] evt;
        logic [N_ALM-1:0] st;
        logic [N_ALM-1:0] en;

        // Map this channel's event pulses onto alarm bit positions.
        always_comb begin
            evt          = '0;
            evt[ALM_OOF] = oof_evt[c];
            evt[ALM_PAR] = par_evt[c];
        end

        alarm_chan_stat u_ch (
            .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr[c]),
            .en_wr(en_wr[c]), .en_wdata(bus_wdata[N_ALM-1:0]),
            .stat(st), .en(en), .summ(summ[c])
        );

        // Flatten channel state for the decoder and the raw outputs.
        always_comb begin
            stat_flat[c*N_ALM +: N_ALM] = st;
            en_flat[c*N_ALM +: N_ALM]   = en;
            oof_raw[c]                  = st[ALM_OOF];
            par_raw[c]                  = st[ALM_PAR];
        end
    end

    // Shared level interrupt and constant read parity.
    always_comb begin
        alarm_irq = |summ;
        bus_rpar  = 1'b0;
    end
endmodule

// File: rtl/alarm_status_agg_chk.sv
// Checker: temporal properties at the ports of alarm_status_agg, attached by bind.
// Assumes a synchronous active-low reset; every property is disabled while reset is low.
module alarm_status_agg_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic [7:0]      bus_rdata,
    input logic            bus_rpar,
    input logic [N_CH-1:0] oof_evt,
    input logic [N_CH-1:0] par_evt,
    input logic [N_CH-1:0] oof_raw,
    input logic [N_CH-1:0] par_raw,
    input logic            alarm_irq
);
    // R10: read parity never rises.
    p_rpar_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rpar);

    // R3 and R5: every event shows on the raw output one clock later.
    p_evt_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|{oof_evt, par_evt}) |=>
            (((oof_raw & $past(oof_evt)) == $past(oof_evt)) &&
             ((par_raw & $past(par_evt)) == $past(par_evt))));

    // R8: the interrupt needs at least one held alarm.
    p_irq_has_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (|{oof_raw, par_raw}));

    // R9: without reads or events, the held status does not move.
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !(|{oof_evt, par_evt})) |=> ($stable(oof_raw) && $stable(par_raw)));

    // R11: read data holds while no read strobe is given.
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind alarm_status_agg alarm_status_agg_chk #(.N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rpar(bus_rpar), .oof_evt(oof_evt), .par_evt(par_evt),
    .oof_raw(oof_raw), .par_raw(par_raw), .alarm_irq(alarm_irq)
);

// File: tb/alarm_status_agg_tb_top.sv
// Bench: a behavioural reference model is stepped every clock and compared with the ports.
// Directed checks name the requirements; a seeded random phase follows.
`timescale 1ns/1ps
module alarm_status_agg_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [17:0] bus_addr = '0;
    logic        bus_rd = 0, bus_wr = 0, bus_wpar = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rpar;
    logic [7:0]  oof_evt = '0, par_evt = '0;
    logic [7:0]  oof_raw, par_raw;
    logic        alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    alarm_status_agg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar),
        .bus_rdata(bus_rdata), .bus_rpar(bus_rpar), .oof_evt(oof_evt),
        .par_evt(par_evt), .oof_raw(oof_raw), .par_raw(par_raw),
        .alarm_irq(alarm_irq)
    );

    // Reference model state.
    bit [1:0]   m_stat [8];
    bit [1:0]   m_en   [8];
    logic [7:0] m_rdata = 8'h00;
    byte        id_b   [4] = '{8'hDC, 8'h01, 8'h22, 8'h82};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input int off);
        logic [7:0] v = 8'h00;
        if (off < 4) v = id_b[off];
        else if (off == 4) for (int c = 0; c < 8; c++) v[c] = |(m_stat[c] & m_en[c]);
        else if (off >= 8 && off < 16) v = {6'b0, m_stat[off-8]};
        else if (off >= 16 && off < 24) v = {6'b0, m_en[off-16]};
        return v;
    endfunction

    // One clock: drive, advance the model, compare all outputs after the edge.
    task automatic step(input bit rd, input bit wr, input int off, input logic [7:0] wd,
                        input bit wp, input logic [7:0] oe, input logic [7:0] pe,
                        input bit off_base = 0);
        logic [7:0] s_oof, s_par, irq_v;
        bit         hit;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_wdata = wd; bus_wpar = wp;
        oof_evt = oe; par_evt = pe;
        bus_addr = {off_base ? 13'h0800 : 13'h1800, 5'(off)};
        hit = !off_base;
        if (rd && hit) m_rdata = m_read(off);
        for (int c = 0; c < 8; c++) begin
            bit clr_c = rd && hit && (off == 8 + c);
            m_stat[c] = (clr_c ? 2'b00 : m_stat[c]) | {pe[c], oe[c]};
        end
        if (wr && hit && off >= 16 && off < 24) m_en[off-16] = wd[1:0];
        @(posedge clk); #1;
        irq_v = 0;
        for (int c = 0; c < 8; c++) begin
            s_oof[c] = m_stat[c][0];
            s_par[c] = m_stat[c][1];
            irq_v[0] = irq_v[0] | (|(m_stat[c] & m_en[c]));
        end
        chk("R11 rdata model", bus_rdata, m_rdata);
        chk("R8 irq model", {7'b0, alarm_irq}, irq_v);
        chk("R9 oof_raw model", oof_raw, s_oof);
        chk("R9 par_raw model", par_raw, s_par);
        chk("R10 rpar", {7'b0, bus_rpar}, 8'h00);
    endtask

    task automatic idle();
        step(0, 0, 0, 8'h00, 0, 8'h00, 8'h00);
    endtask

    task automatic rd_reg(input int off);
        step(1, 0, off, 8'h00, 0, 8'h00, 8'h00);
    endtask

    task automatic wr_reg(input int off, input logic [7:0] d, input bit wp = 0);
        step(0, 1, off, d, wp, 8'h00, 8'h00);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin m_stat[c] = 0; m_en[c] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R12 rdata after reset", bus_rdata, 8'h00);
        chk("R12 irq after reset", {7'b0, alarm_irq}, 8'h00);
        chk("R12 raw after reset", oof_raw | par_raw, 8'h00);
        rd_reg(16 + 7);
        chk("R12 enable zero after reset", bus_rdata, 8'h00);

        // R1: identification bytes, then a write attempt.
        for (int i = 0; i < 4; i++) begin
            rd_reg(i);
            chk("R1 id byte", bus_rdata, id_b[i]);
        end
        wr_reg(0, 8'h55);
        rd_reg(0);
        chk("R1 id after write", bus_rdata, 8'hDC);

        // R2: accesses outside the base window.
        step(0, 1, 16 + 2, 8'h03, 0, 8'h00, 8'h00, 1);
        step(1, 0, 0, 8'h00, 0, 8'h00, 8'h00, 1);
        chk("R2 off-base read holds", bus_rdata, 8'hDC);
        rd_reg(16 + 2);
        chk("R2 off-base write ignored", bus_rdata, 8'h00);

        // R3, R9: events are held.
        step(0, 0, 0, 8'h00, 0, 8'h01, 8'h20);
        chk("R9 oof_raw", oof_raw, 8'h01);
        chk("R9 par_raw", par_raw, 8'h20);
        chk("R8 irq masked", {7'b0, alarm_irq}, 8'h00);
        rd_reg(8 + 0);
        chk("R3 status ch0", bus_rdata, 8'h01);
        rd_reg(8 + 0);
        chk("R4 cleared on read", bus_rdata, 8'h00);

        // R6, R7, R8: enable and summary.
        wr_reg(16 + 5, 8'hFF);
        rd_reg(16 + 5);
        chk("R6 enable readback", bus_rdata, 8'h03);
        chk("R8 irq raised", {7'b0, alarm_irq}, 8'h01);
        rd_reg(4);
        chk("R7 summary", bus_rdata, 8'h20);
        rd_reg(4);
        chk("R7 summary not cleared", bus_rdata, 8'h20);

        // R5: a new event in the same cycle as the clearing read survives.
        step(1, 0, 8 + 5, 8'h00, 0, 8'h00, 8'h20);
        chk("R5 read returns old value", bus_rdata, 8'h02);
        chk("R5 event kept", par_raw, 8'h20);
        chk("R8 irq held", {7'b0, alarm_irq}, 8'h01);
        rd_reg(8 + 5);
        chk("R4 second read value", bus_rdata, 8'h02);
        chk("R8 irq dropped", {7'b0, alarm_irq}, 8'h00);

        // R10: write parity has no effect.
        wr_reg(16 + 3, 8'h01, 1);
        rd_reg(16 + 3);
        chk("R10 write with parity 1", bus_rdata, 8'h01);
        wr_reg(16 + 3, 8'h02, 0);
        rd_reg(16 + 3);
        chk("R10 write with parity 0", bus_rdata, 8'h02);

        // R11: unmapped offset, then hold without reads.
        rd_reg(31);
        chk("R11 unmapped reads zero", bus_rdata, 8'h00);
        rd_reg(1);
        idle(); idle();
        chk("R11 rdata hold", bus_rdata, 8'h01);

        // Random phase, compared against the model on every clock.
        void'($urandom(7));
        for (int i = 0; i < 2000; i++) begin
            int k = int'($urandom_range(0, 9));
            int o = int'($urandom_range(0, 31));
            step(k < 4, k >= 4 && k < 6, o, 8'($urandom), 1'($urandom),
                 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom), k == 9);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule